// File: doc/BRIEF.md
# Console Toggle Request Encoder

This block sits between the momentary command toggles of a front panel and a microprogrammed console loop. It produces two outputs. The first is a single latched request that tells the microcode some command toggle has been operated. The second is a 3-bit command code that the microcode uses as branch bits to pick the routine for that command.

Only the request is stored. The command code is a live combinational function of the toggle levels. If the operator lets go of the toggle before the microcode samples the code, the code reads as zero even though the request is still pending. The controller clears the request with a synchronous strobe once it has taken the branch. Switch debounce timing is left to the microcode.

Top module: `console_toggle_encoder`

## Requirements
- R1: While rst_ni is low, req_o is 0. After reset is released, req_o stays 0 until a set condition occurs.
- R2: With exactly one toggle active, code_o takes the value for that toggle: load address gives 3'd7, continue gives 3'd6, examine gives 3'd5, deposit gives 3'd4, and start gives 3'd2.
- R3: With no toggle active, code_o is 3'd0.
- R4: With several toggles active, code_o is the bitwise OR of their individual codes. In that case bit 0 is examine|load, bit 1 is continue|load|start, and bit 2 is examine|continue|load|deposit.
- R5: If load, continue, examine or deposit is high at a rising clock edge and req_clr_i is low, req_o is 1 after that edge.
- R6: The start toggle on its own does not set req_o.
- R7: When neither a set condition nor req_clr_i is present at an edge, req_o keeps its value, including after every toggle has been released.
- R8: If req_clr_i is high at a rising edge, req_o is 0 after that edge, even when a set condition is present at the same edge.
- R9: code_o is not stored. Once the toggles are released it reads 3'd0, while req_o may still be 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_adrs_i | input | 1 | Load-address toggle level |
| exam_i | input | 1 | Examine toggle level |
| dep_i | input | 1 | Deposit toggle level |
| cont_i | input | 1 | Continue toggle level |
| start_i | input | 1 | Start toggle level |
| req_clr_i | input | 1 | Synchronous clear strobe for the request |
| req_o | output | 1 | Latched switch-activity request |
| code_o | output | 3 | Live command code |

## Verification
The bench drives all 32 toggle combinations and checks each code against an OR of table values computed in the bench. A swapped table entry or a wrong gate in any code bit would show up in at least one of those combinations. For each combination it also checks that the request sets only when a non-start toggle is high, so a design that let start set the request would fail. It checks that the request survives the release of the toggles while the code drops to zero, which catches a design that latches the code or lets the request decay. Finally, it asserts clear together with the same toggles, so a design that gave set priority over clear would leave the request high.

// File: rtl/cte_pkg.sv
package cte_pkg;
  localparam int NUM_TOG = 5;
  localparam int CODE_W  = 3;

  // toggle vector positions
  localparam int T_LOAD  = 0;
  localparam int T_CONT  = 1;
  localparam int T_EXAM  = 2;
  localparam int T_DEP   = 3;
  localparam int T_START = 4;

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [NUM_TOG-1:0] tog_vec_t;

  // toggles that raise the activity request
  localparam tog_vec_t REQ_MASK = tog_vec_t'((1 << T_LOAD) | (1 << T_CONT) |
                                              (1 << T_EXAM) | (1 << T_DEP));

  function automatic code_t tog_code(input int idx);
    case (idx)
      T_LOAD:  return 3'd7;
      T_CONT:  return 3'd6;
      T_EXAM:  return 3'd5;
      T_DEP:   return 3'd4;
      T_START: return 3'd2;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/cte_code_enc.sv
module cte_code_enc
  import cte_pkg::*;
(
  input  tog_vec_t tog_i,
  output code_t    code_o,
  output logic     set_o
);
  code_t part [NUM_TOG];

  for (genvar g = 0; g < NUM_TOG; g++) begin : g_part
    assign part[g] = tog_i[g] ? tog_code(g) : '0;
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_TOG; i++) code_o |= part[i];
  end

  assign set_o = |(tog_i & REQ_MASK);
endmodule

// File: rtl/cte_req_latch.sv
module cte_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_o <= 1'b0;
    else if (clr_i)  req_o <= 1'b0;  // clear wins
    else if (set_i)  req_o <= 1'b1;
  end

  assert_clr_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !req_o);
  assert_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> req_o);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(req_o));
endmodule

// File: rtl/console_toggle_encoder.sv
module console_toggle_encoder
  import cte_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_adrs_i,
  input  logic       exam_i,
  input  logic       dep_i,
  input  logic       cont_i,
  input  logic       start_i,
  input  logic       req_clr_i,
  output logic       req_o,
  output logic [2:0] code_o
);
  tog_vec_t tog;
  logic     set;

  always_comb begin
    tog          = '0;
    tog[T_LOAD]  = load_adrs_i;
    tog[T_CONT]  = cont_i;
    tog[T_EXAM]  = exam_i;
    tog[T_DEP]   = dep_i;
    tog[T_START] = start_i;
  end

  cte_code_enc u_enc (
    .tog_i  (tog),
    .code_o (code_o),
    .set_o  (set)
  );

  cte_req_latch u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clr_i  (req_clr_i),
    .req_o  (req_o)
  );

  assert_idle_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_adrs_i || exam_i || dep_i || cont_i || start_i) |-> code_o == 3'd0);
  assert_start_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !load_adrs_i && !exam_i && !dep_i && !cont_i && !req_clr_i && !req_o)
      |=> !req_o);
  assert_load_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_adrs_i |-> code_o == 3'd7);
endmodule

// File: tb/console_toggle_encoder_tb_top.sv
module console_toggle_encoder_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 0, ex = 0, dp = 0, ct = 0, st = 0, clr = 0;
  logic       req;
  logic [2:0] code;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  console_toggle_encoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_adrs_i(ld), .exam_i(ex), .dep_i(dp),
    .cont_i(ct), .start_i(st), .req_clr_i(clr), .req_o(req), .code_o(code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // v bit order: 0 load, 1 cont, 2 exam, 3 dep, 4 start
  function automatic int exp_code(input int v);
    int c = 0;
    if (v[0]) c |= 7;
    if (v[1]) c |= 6;
    if (v[2]) c |= 5;
    if (v[3]) c |= 4;
    if (v[4]) c |= 2;
    return c;
  endfunction

  task automatic drive(input int v);
    ld = v[0]; ct = v[1]; ex = v[2]; dp = v[3]; st = v[4];
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 req in reset", req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req after reset", req, 0);
    chk("R3 idle code", code, 0);

    for (int v = 0; v < 32; v++) begin
      int es;
      es = (v & 5'b01111) != 0;
      drive(v); clr = 0;
      #1;
      if ($countones(v) == 1) chk("R2 single code", code, exp_code(v));
      else if (v == 0)        chk("R3 idle code", code, 0);
      else                    chk("R4 or code", code, exp_code(v));
      @(negedge clk);
      if (v == 16) chk("R6 start no req", req, 0);
      else         chk("R5 req set", req, es);
      drive(0);
      #1;
      chk("R9 code live", code, 0);
      @(negedge clk);
      chk("R7 req hold", req, es);
      drive(v); clr = 1;
      @(negedge clk);
      chk("R8 clear wins", req, 0);
      drive(0); clr = 0;
      @(negedge clk);
      chk("R7 req stays clear", req, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule